// File: doc/BRIEF.md
# I2C Target Interface Controller

This block is the target (slave) side of an I2C bus, seen by a host processor as five small registers: control, status, interrupt enable, own address and a shared data port. It samples the bus clock and data lines through two-flop synchronisers and finds START and STOP conditions. It shifts in the address byte and acknowledges it when the 7-bit address matches its own address, or when it matches the general-call address and that feature is turned on.

Each data byte is a handshake with the processor. A received byte raises a sticky status bit, and the block holds the clock line low until software reads the byte and clears the bit. Software may ask for that byte to be refused with a NACK. For a read request the block raises a data-empty bit and holds the clock low until software writes the next byte to the data port and clears the bit. The byte is then shifted out most significant bit first. The interrupt line is the OR of all status bits that are enabled.

Register offsets on `reg_addr`: 0 control, 1 status, 2 interrupt enable, 3 own address (bits 6:0), 4 data port (a write loads the transmit byte, a read returns the last received byte). Bus outputs are open-drain enables: a 1 pulls the line low.

Top module: `i2c_target_ctrl`

## Requirements
- R1: After reset, the control, status, interrupt-enable and own-address registers read 0, `irq` is 0, and `scl_oe` and `sda_oe` are 0.
- R2: With the interface enabled (control bit 2), an address byte whose upper 7 bits equal the own address is acknowledged by pulling SDA low in the ninth clock, and status bit 0 (address seen) is set. Any other address gets no acknowledge and leaves the status register unchanged.
- R3: With control bit 1 set, address 0x00 with the write direction is acknowledged and sets status bit 6 (general call) as well as bit 0. With control bit 1 clear, the same address is not acknowledged.
- R4: A write to the status register clears each bit that is written as 0 and leaves each bit that is written as 1 unchanged.
- R5: `irq` is 1 exactly when the AND of the status register and the interrupt-enable register (same bit layout) is nonzero. It follows that AND one clock later.
- R6: A byte written by the controller appears on the data port and sets status bit 1 (data received). SCL is held low from the end of that byte's eighth bit until bit 1 is cleared, and the byte is then acknowledged.
- R7: While control bit 0 (forced NACK) is set at the moment software releases a received byte, that byte is answered with NACK instead of ACK.
- R8: A matching address with the read direction sets status bit 5 (transmit mode) and bit 3 (data empty). The byte written to the data port is sent MSB first once bit 3 is cleared. An ACK from the controller sets bit 2 (sent) and bit 3 again; a NACK sets bit 2 only.
- R9: A STOP after this target was addressed sets status bit 4, and the block goes back to waiting for an address.
- R10: With control bit 2 clear, the block ignores the bus: no acknowledge and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The assertions assume a well-formed bus. The controller moves SDA only while SCL is low, except at START and STOP, and every SCL high and low phase lasts longer than the synchroniser latency plus one clock. They also assume the processor makes one register access at a time. The bench controller keeps each half period at twenty system clocks, changes SDA only after SCL has been low for that long, and waits until the SCL line is really high before it counts the high phase, so clock stretching is honoured. The processor side polls the status register and makes one access at a time.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  // register offsets
  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_IEN  = 2;
  localparam int OFS_OWN  = 3;
  localparam int OFS_DATA = 4;

  // control bits
  localparam int C_FNACK  = 0;
  localparam int C_GCEN   = 1;
  localparam int C_ENABLE = 2;
  localparam int C_BUFSEL = 3;
  localparam int CTRL_W   = 4;

  // status / interrupt-enable bits
  localparam int S_ADDR  = 0;
  localparam int S_RCVD  = 1;
  localparam int S_SENT  = 2;
  localparam int S_EMPTY = 3;
  localparam int S_STOP  = 4;
  localparam int S_TXM   = 5;
  localparam int S_GCALL = 6;
  localparam int STAT_W  = 7;

  typedef enum logic [3:0] {
    T_IDLE, T_ADDR, T_AACK, T_RX, T_RHOLD, T_RACK, T_TLOAD, T_TX, T_TACK
  } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              gc_en,
  input  logic              fnack,
  input  logic [6:0]        own_addr,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              hold_rx,
  input  logic              hold_tx,
  input  logic              scl_s,
  input  logic              sda_s,
  output logic              ev_addr,
  output logic              ev_gc,
  output logic              ev_rw,
  output logic              ev_rx,
  output logic              ev_txd,
  output logic              ev_txack,
  output logic              ev_stop,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              scl_oe,
  output logic              sda_oe
);
  tgt_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              scl_q, sda_q, sel, rw_q, nack_q, acked;

  logic scl_rise, scl_fall, start_c, stop_c, byte_end, m_own, m_gc;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign byte_end = scl_fall && (cnt == CNT_W'(BYTE_W));
  assign m_gc     = gc_en && (sh[7:1] == 7'd0) && !sh[0];
  assign m_own    = (sh[7:1] == own_addr) && (sh[7:1] != 7'd0);

  logic quiet;
  assign quiet = en && !start_c && !stop_c;

  assign ev_addr  = quiet && state == T_ADDR && byte_end && (m_own || m_gc);
  assign ev_gc    = m_gc;
  assign ev_rw    = sh[0];
  assign ev_rx    = quiet && state == T_RX && byte_end;
  assign rx_byte  = sh;
  assign ev_txd   = quiet && state == T_TACK && scl_rise;
  assign ev_txack = ~sda_s;
  assign ev_stop  = en && stop_c && sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1; sda_q <= 1'b1;
      state <= T_IDLE; cnt <= '0; sh <= '0; sel <= 1'b0;
      rw_q <= 1'b0; nack_q <= 1'b0; acked <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (!en || stop_c) begin
        state <= T_IDLE; sel <= 1'b0;
        scl_oe <= 1'b0; sda_oe <= 1'b0;
      end else if (start_c) begin
        state <= T_ADDR; cnt <= '0; sel <= 1'b0;
        scl_oe <= 1'b0; sda_oe <= 1'b0;
      end else begin
        case (state)
          T_ADDR, T_RX: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (byte_end) begin
              if (state == T_RX) begin
                state <= T_RHOLD; scl_oe <= 1'b1;
              end else if (m_own || m_gc) begin
                state <= T_AACK; sda_oe <= 1'b1; sel <= 1'b1; rw_q <= sh[0];
              end else begin
                state <= T_IDLE;
              end
            end
          end
          T_AACK: if (scl_fall) begin
            sda_oe <= 1'b0; cnt <= '0;
            if (rw_q) begin state <= T_TLOAD; scl_oe <= 1'b1; end
            else state <= T_RX;
          end
          T_RHOLD: if (!hold_rx) begin
            sda_oe <= ~fnack; nack_q <= fnack; state <= T_RACK;
          end
          T_RACK: begin
            scl_oe <= 1'b0;
            if (scl_fall) begin
              sda_oe <= 1'b0; cnt <= '0;
              state  <= nack_q ? T_IDLE : T_RX;
            end
          end
          T_TLOAD: if (!hold_tx) begin
            sh <= tx_byte; sda_oe <= ~tx_byte[BYTE_W-1]; cnt <= '0; state <= T_TX;
          end
          T_TX: begin
            scl_oe <= 1'b0;
            if (scl_rise) cnt <= cnt + 1'b1;
            else if (byte_end) begin
              sda_oe <= 1'b0; state <= T_TACK;
            end else if (scl_fall && cnt != '0) begin
              sh <= {sh[BYTE_W-2:0], 1'b0}; sda_oe <= ~sh[BYTE_W-2];
            end
          end
          T_TACK: begin
            if (scl_rise) acked <= ~sda_s;
            else if (scl_fall) begin
              if (acked) begin state <= T_TLOAD; scl_oe <= 1'b1; end
              else state <= T_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: a STOP releases both lines and parks the engine
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (en && stop_c) |=> (state == T_IDLE && !scl_oe && !sda_oe));

  // R2: at most one bus event per cycle
  assert_one_event_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_addr, ev_rx, ev_txd, ev_stop}));

  // R7: the acknowledge driven after a hold reflects the forced-NACK input
  assert_fnack_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == T_RHOLD && state == T_RACK) |-> (sda_oe == !$past(fnack)));
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int REG_AW      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic [CTRL_W-1:0] ctrl;
  logic [STAT_W-1:0] stat, ien, stat_n;
  logic [6:0]        own;
  logic [BYTE_W-1:0] tx_buf, rx_buf, rx_byte;
  logic scl_s, sda_s;
  logic ev_addr, ev_gc, ev_rw, ev_rx, ev_txd, ev_txack, ev_stop;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst(rst), .din(scl_i), .dout(scl_s));
  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst(rst), .din(sda_i), .dout(sda_s));

  i2c_tgt_engine u_engine (
    .clk(clk), .rst(rst),
    .en(ctrl[C_ENABLE]), .gc_en(ctrl[C_GCEN]), .fnack(ctrl[C_FNACK]),
    .own_addr(own), .tx_byte(tx_buf),
    .hold_rx(stat[S_RCVD]), .hold_tx(stat[S_EMPTY]),
    .scl_s(scl_s), .sda_s(sda_s),
    .ev_addr(ev_addr), .ev_gc(ev_gc), .ev_rw(ev_rw), .ev_rx(ev_rx),
    .ev_txd(ev_txd), .ev_txack(ev_txack), .ev_stop(ev_stop),
    .rx_byte(rx_byte), .scl_oe(scl_oe), .sda_oe(sda_oe));

  logic wr_stat;
  assign wr_stat = reg_wr && reg_addr == REG_AW'(OFS_STAT);

  always_comb begin
    stat_n = wr_stat ? (stat & reg_wdata[STAT_W-1:0]) : stat;
    if (ev_addr) begin
      stat_n[S_ADDR]  = 1'b1;
      stat_n[S_TXM]   = ev_rw;
      if (ev_rw) stat_n[S_EMPTY] = 1'b1;
      if (ev_gc) stat_n[S_GCALL] = 1'b1;
    end
    if (ev_rx)  stat_n[S_RCVD] = 1'b1;
    if (ev_txd) begin
      stat_n[S_SENT] = 1'b1;
      if (ev_txack) stat_n[S_EMPTY] = 1'b1;
    end
    if (ev_stop) stat_n[S_STOP] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0; stat <= '0; ien <= '0; own <= '0;
      tx_buf <= '0; rx_buf <= '0; reg_rdata <= '0; irq <= 1'b0;
    end else begin
      stat <= stat_n;
      irq  <= |(stat & ien);
      if (ev_rx) rx_buf <= rx_byte;
      if (reg_wr) begin
        case (reg_addr)
          REG_AW'(OFS_CTRL): ctrl   <= reg_wdata[CTRL_W-1:0];
          REG_AW'(OFS_IEN):  ien    <= reg_wdata[STAT_W-1:0];
          REG_AW'(OFS_OWN):  own    <= reg_wdata[6:0];
          REG_AW'(OFS_DATA): tx_buf <= reg_wdata;
          default: ;
        endcase
      end
      if (reg_rd) begin
        case (reg_addr)
          REG_AW'(OFS_CTRL): reg_rdata <= 8'(ctrl);
          REG_AW'(OFS_STAT): reg_rdata <= 8'(stat);
          REG_AW'(OFS_IEN):  reg_rdata <= 8'(ien);
          REG_AW'(OFS_OWN):  reg_rdata <= {1'b0, own};
          REG_AW'(OFS_DATA): reg_rdata <= rx_buf;
          default:           reg_rdata <= '0;
        endcase
      end
    end
  end

  // R6: a freshly received byte is always accompanied by a held clock
  assert_stretch_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[S_RCVD]) |-> scl_oe);

  // R4: writing 0 to the stop bit clears it unless a stop arrives together
  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !reg_wdata[S_STOP] && !ev_stop) |=> !stat[S_STOP]);

  // R8: a read request raises transmit mode and data empty
  assert_txmode_R8: assert property (@(posedge clk) disable iff (rst)
    (ev_addr && ev_rw) |=> (stat[S_TXM] && stat[S_EMPTY]));
endmodule

// File: tb/tb_i2c_target_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_target_ctrl;
  localparam int H = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe, scl_line, sda_line;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;

  assign scl_line = ~(m_scl_low | scl_oe);
  assign sda_line = ~(m_sda_low | sda_oe);

  i2c_target_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe));

  int total = 0, bad = 0;
  logic [7:0] wr_q[$], rd_q[$], tx_src[$];
  logic [7:0] ctrl_v = 8'h00;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  // ---- bus controller model ----
  task automatic m_pulse(output bit s);
    m_scl_low = 1'b0;
    while (scl_line !== 1'b1) @(negedge clk);
    wclk(H); s = sda_line;
    m_scl_low = 1'b1; wclk(H);
  endtask

  task automatic m_start();
    m_sda_low = 1'b0; m_scl_low = 1'b0;
    while (scl_line !== 1'b1) @(negedge clk);
    wclk(H); m_sda_low = 1'b1; wclk(H); m_scl_low = 1'b1; wclk(H);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; wclk(H); m_scl_low = 1'b0;
    while (scl_line !== 1'b1) @(negedge clk);
    wclk(H); m_sda_low = 1'b0; wclk(H);
  endtask

  task automatic m_wbyte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) begin m_sda_low = ~b[i]; m_pulse(s); end
    m_sda_low = 1'b0; m_pulse(s); ack = ~s;
  endtask

  task automatic m_rbyte(input bit ack_it, output logic [7:0] b);
    bit s;
    m_sda_low = 1'b0;
    for (int i = 0; i < 8; i++) begin m_pulse(s); b = {b[6:0], s}; end
    m_sda_low = ack_it; m_pulse(s); m_sda_low = 1'b0;
  endtask

  task automatic m_xfer_write(input logic [6:0] a, input logic [7:0] d[$],
                              output bit aack, output int nacks);
    bit k;
    nacks = 0;
    m_start(); m_wbyte({a, 1'b0}, aack);
    if (aack) begin
      foreach (d[i]) begin
        wr_q.push_back(d[i]);
        m_wbyte(d[i], k);
        if (!k) begin nacks++; break; end
      end
    end
    m_stop();
  endtask

  // monitor side of the read scoreboard
  task automatic m_xfer_read(input logic [6:0] a, input int n, output bit aack);
    logic [7:0] b, e;
    m_start(); m_wbyte({a, 1'b1}, aack);
    if (aack) begin
      for (int i = 0; i < n; i++) begin
        m_rbyte(i != n - 1, b);
        e = (rd_q.size() != 0) ? rd_q.pop_front() : 8'hxx;
        check(b === e, "R8", "byte read by controller", b, e);
      end
    end
    m_stop();
  endtask

  // processor side: polls status until a stop is seen
  task automatic cpu_serve(input bit use_fnack);
    logic [7:0] st, d, e;
    bit done = 0;
    while (!done) begin
      reg_read(3'd1, st);
      if (st[1]) begin
        check(scl_oe === 1'b1, "R6", "scl held while byte pending", scl_oe, 1);
        reg_read(3'd4, d);
        e = (wr_q.size() != 0) ? wr_q.pop_front() : 8'hxx;
        check(d === e, "R6", "received byte on data port", d, e);
        if (use_fnack) reg_write(3'd0, ctrl_v | 8'h01);
        reg_write(3'd1, 8'hFD);
      end
      if (st[3]) begin
        d = (tx_src.size() != 0) ? tx_src.pop_front() : 8'hFF;
        reg_write(3'd4, d);
        rd_q.push_back(d);
        reg_write(3'd1, 8'hF7);
      end
      if (st[4]) done = 1;
    end
  endtask

  // watchdog
  initial begin
    wclk(150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    bit aack;
    int nk;
    wclk(5); rst = 1'b0; wclk(2);

    // R1 reset state
    reg_read(3'd0, v); check(v == 8'h00, "R1", "control after reset", v, 0);
    reg_read(3'd1, v); check(v == 8'h00, "R1", "status after reset", v, 0);
    reg_read(3'd2, v); check(v == 8'h00, "R1", "irq enable after reset", v, 0);
    reg_read(3'd3, v); check(v == 8'h00, "R1", "own address after reset", v, 0);
    check({irq, scl_oe, sda_oe} == 3'b000, "R1", "irq/line drives after reset",
          {irq, scl_oe, sda_oe}, 0);

    reg_write(3'd3, 8'h2A);
    ctrl_v = 8'h04; reg_write(3'd0, ctrl_v);

    // R2 foreign address ignored
    m_xfer_write(7'h15, '{8'h77}, aack, nk);
    check(aack == 0, "R2", "ack for foreign address", aack, 0);
    reg_read(3'd1, v); check(v == 8'h00, "R2", "status after foreign address", v, 0);

    // R2 / R6 / R9 two-byte write with stretching
    fork
      m_xfer_write(7'h2A, '{8'hA5, 8'h3C}, aack, nk);
      cpu_serve(0);
    join
    check(aack == 1, "R2", "ack for own address", aack, 1);
    check(nk == 0, "R6", "data bytes acknowledged", nk, 0);
    reg_read(3'd1, v); check(v == 8'h11, "R9", "status after write and stop", v, 8'h11);

    // R5 interrupt follows status AND enable
    reg_write(3'd2, 8'h10); wclk(2);
    check(irq == 1'b1, "R5", "irq with stop enabled", irq, 1);
    reg_write(3'd2, 8'h02); wclk(2);
    check(irq == 1'b0, "R5", "irq with only rcvd enabled", irq, 0);
    reg_write(3'd2, 8'h00);

    // R4 write-zero-to-clear
    reg_write(3'd1, 8'hEF);
    reg_read(3'd1, v); check(v == 8'h01, "R4", "stop cleared, addr kept", v, 8'h01);
    reg_write(3'd1, 8'h00);
    reg_read(3'd1, v); check(v == 8'h00, "R4", "all cleared", v, 0);

    // R7 forced NACK
    fork
      m_xfer_write(7'h2A, '{8'h11, 8'h22}, aack, nk);
      cpu_serve(1);
    join
    check(nk == 1, "R7", "byte refused with forced nack", nk, 1);
    ctrl_v = 8'h04; reg_write(3'd0, ctrl_v);
    reg_write(3'd1, 8'h00);

    // R8 read with two bytes, last one nacked by controller
    tx_src.push_back(8'hC3); tx_src.push_back(8'h5A);
    fork
      m_xfer_read(7'h2A, 2, aack);
      cpu_serve(0);
    join
    check(aack == 1, "R8", "ack for read request", aack, 1);
    reg_read(3'd1, v); check(v == 8'h35, "R8", "status after read", v, 8'h35);
    reg_write(3'd1, 8'h00);

    // R3 general call
    ctrl_v = 8'h06; reg_write(3'd0, ctrl_v);
    fork
      m_xfer_write(7'h00, '{8'h5E}, aack, nk);
      cpu_serve(0);
    join
    check(aack == 1, "R3", "general call acknowledged", aack, 1);
    reg_read(3'd1, v); check(v == 8'h51, "R3", "general call status", v, 8'h51);
    reg_write(3'd1, 8'h00);
    ctrl_v = 8'h04; reg_write(3'd0, ctrl_v);
    m_xfer_write(7'h00, '{8'h5E}, aack, nk);
    check(aack == 0, "R3", "general call when disabled", aack, 0);

    // R10 interface disabled
    ctrl_v = 8'h00; reg_write(3'd0, ctrl_v);
    m_xfer_write(7'h2A, '{8'h99}, aack, nk);
    check(aack == 0, "R10", "ack while disabled", aack, 0);
    reg_read(3'd1, v); check(v == 8'h00, "R10", "status while disabled", v, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule